// File: doc/BRIEF.md
# Stream Round-Trip Latency Timer

This block measures how long a packet takes to travel out through a transmit AXI4-Stream port and come back on a receive AXI4-Stream port. It watches only the handshake signals. It does not look at the data. Software or a test sequencer pulses `start_i` to open a measurement. The timer begins on the first accepted beat of the next transmitted packet. It stops on the first valid beat seen on the receive side. The result is a count of clock cycles. At a 390.625 MHz stream clock, each counted cycle stands for 2.56 ns; the block does not convert the count to time.

The block follows packet boundaries on the transmit side at all times. A first-beat marker is set when a beat carrying tlast is accepted. Because of this, only a true packet head can start the timer. This holds even when `start_i` arrives in the middle of a packet. Once a result is captured, it is frozen and flagged until the next start pulse. If no packet ever returns, the counter stops at its maximum value instead of wrapping.

Top module: `rtt_meter`

## Requirements
- R1: After reset, `cycles_o` is 0 and `done_o` is 0. The first-beat marker is set, so the first accepted transmit beat after reset counts as a packet head.
- R2: A `start_i` pulse clears `cycles_o` to 0 and `done_o` to 0 on the following edge, and halts any running measurement. Start has priority over a transmit or receive event in the same cycle: such a transmit beat does not start the timer.
- R3: The timer starts on a transmit beat that is accepted (`tx_valid_i` and `tx_ready_i` both 1) while the first-beat marker is set. A beat with valid high and ready low does not start it. While running, `cycles_o` rises by exactly one per clock.
- R4: While running, the first cycle with `rx_valid_i` = 1 stops the timer and sets `done_o` on the same edge. If the transmit head is accepted in cycle t and the receive beat arrives in cycle t+d (d ≥ 1), the result is d. `rx_valid_i` while the timer is not running has no effect.
- R5: While `done_o` is 1, `cycles_o` and `done_o` hold until the next `start_i`. Later transmitted packets and received beats do not restart the timer.
- R6: The first-beat marker clears on every accepted beat without tlast and sets on every accepted beat with tlast. `start_i` does not change the marker. A start issued in the middle of a packet therefore times the packet that follows. A single-beat packet (head carrying tlast) starts the timer.
- R7: The counter saturates: once `cycles_o` is all ones it stays there and does not wrap to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Single-cycle pulse that clears and opens a measurement |
| tx_valid_i | input | 1 | Transmit stream valid |
| tx_ready_i | input | 1 | Transmit stream ready |
| tx_last_i | input | 1 | Transmit stream last beat of packet |
| rx_valid_i | input | 1 | Receive stream valid |
| cycles_o | output | CNT_W | Measured round-trip time in clock cycles (registered) |
| done_o | output | 1 | Result captured and held (registered) |

## Verification
Every result is registered once. A start pulse or a receive beat sampled at one edge therefore shows on `cycles_o` and `done_o` right after that edge. A transmit head accepted at edge t lets the count rise at edges t+1 onward. The bench drives inputs on the falling edge and samples outputs on a later falling edge, after the edge that produced them. It then puts every input back to idle at that same falling edge. Any idle cycle this inserts is included in the expected count. The vector loop places the receive beat a fixed number of cycles after the accepted head, and the expected result is that distance.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  localparam int unsigned RTT_CNT_W_DEF = 32;

  typedef struct packed {
    logic valid;
    logic ready;
    logic last;
  } tx_hs_t;
endpackage

// File: rtl/rtt_ctrl.sv
module rtt_ctrl
  import rtt_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start_i,
  input  tx_hs_t tx_i,
  input  logic   rx_valid_i,
  output logic   run_o,
  output logic   done_o
);
  logic head_q;
  logic run_q;
  logic done_q;
  logic tx_acc;
  logic rx_hit;

  assign tx_acc = tx_i.valid & tx_i.ready;
  assign rx_hit = run_q & rx_valid_i;

  // packet-head marker follows the transmit stream only
  always_ff @(posedge clk) begin
    if (rst)         head_q <= 1'b1;
    else if (tx_acc) head_q <= tx_i.last;
  end

  always_ff @(posedge clk) begin
    if (rst)                              run_q <= 1'b0;
    else if (start_i)                     run_q <= 1'b0;
    else if (rx_hit)                      run_q <= 1'b0;
    else if (tx_acc && head_q && !done_q) run_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)          done_q <= 1'b0;
    else if (start_i) done_q <= 1'b0;
    else if (rx_hit)  done_q <= 1'b1;
  end

  assign run_o  = run_q;
  assign done_o = done_q;
endmodule

// File: rtl/rtt_sat_cnt.sv
module rtt_sat_cnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)                cnt_q <= '0;
    else if (inc_i && cnt_q != MAXV) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rtt_meter.sv
module rtt_meter
  import rtt_pkg::*;
#(
  parameter int unsigned CNT_W = RTT_CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             tx_valid_i,
  input  logic             tx_ready_i,
  input  logic             tx_last_i,
  input  logic             rx_valid_i,
  output logic [CNT_W-1:0] cycles_o,
  output logic             done_o
);
  tx_hs_t tx_hs;
  logic   run;

  assign tx_hs = '{valid: tx_valid_i, ready: tx_ready_i, last: tx_last_i};

  rtt_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .tx_i       (tx_hs),
    .rx_valid_i (rx_valid_i),
    .run_o      (run),
    .done_o     (done_o)
  );

  rtt_sat_cnt #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr_i (start_i),
    .inc_i (run),
    .cnt_o (cycles_o)
  );
endmodule

// File: rtl/rtt_meter_chk.sv
module rtt_meter_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             rx_valid_i,
  input logic [CNT_W-1:0] cycles_o,
  input logic             done_o
);
  localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (cycles_o == '0 && !done_o)); // R1

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (cycles_o == '0 && !done_o)); // R2

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> (cycles_o == $past(cycles_o) ||
                  cycles_o == CNT_W'($past(cycles_o) + 1'b1))); // R3

  AST_DONE_NEEDS_RX: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(rx_valid_i)); // R4

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> ($stable(cycles_o) && done_o)); // R5

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!start_i && cycles_o == ALL1) |=> (cycles_o == ALL1)); // R7
endmodule

bind rtt_meter rtt_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .rx_valid_i (rx_valid_i),
  .cycles_o   (cycles_o),
  .done_o     (done_o)
);

// File: tb/rtt_meter_tb.sv
`timescale 1ns/1ps
module rtt_meter_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, txv = 1'b0, txr = 1'b0, txl = 1'b0, rxv = 1'b0;
  logic [31:0] cyc;
  logic        done;
  logic [5:0]  cyc_s;
  logic        done_s;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rtt_meter u_dut (
    .clk(clk), .rst(rst), .start_i(start), .tx_valid_i(txv), .tx_ready_i(txr),
    .tx_last_i(txl), .rx_valid_i(rxv), .cycles_o(cyc), .done_o(done));

  rtt_meter #(.CNT_W(6)) u_dut_sat (
    .clk(clk), .rst(rst), .start_i(start), .tx_valid_i(txv), .tx_ready_i(txr),
    .tx_last_i(txl), .rx_valid_i(rxv), .cycles_o(cyc_s), .done_o(done_s));

  // {beats, ready stall cycles, rx distance after accepted head}
  localparam logic [23:0] VEC [7] = '{
    {8'd1,  8'd0, 8'd1},
    {8'd1,  8'd0, 8'd5},
    {8'd4,  8'd0, 8'd2},
    {8'd4,  8'd3, 8'd10},
    {8'd8,  8'd2, 8'd8},
    {8'd2,  8'd5, 8'd30},
    {8'd16, 8'd0, 8'd3}
  };

  task automatic beat(input logic v, input logic r, input logic l,
                      input logic rx, input logic st);
    @(negedge clk);
    txv = v; txr = r; txl = l; rxv = rx; start = st;
    @(posedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // sample after the last edge, then return inputs to idle
  task automatic look(input string tag, input logic [31:0] exp_cyc, input logic exp_done);
    @(negedge clk);
    chk({tag, " cycles"}, cyc, exp_cyc);
    chk({tag, " done"}, {31'd0, done}, {31'd0, exp_done});
    txv = 0; txr = 0; txl = 0; rxv = 0; start = 0;
  endtask

  task automatic run_vec(input int nb, input int st, input int d);
    int sent = 0;
    beat(0, 0, 0, 0, 1);
    for (int c = 0; c < st + nb + d + 2; c++) begin
      beat(sent < nb, c >= st, sent == nb - 1, c == st + d, 0);
      if (txv && txr) sent++;
    end
    beat(0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    look("R1 reset", 0, 0);

    // R4: receive beat with no timer running is ignored
    beat(0, 0, 0, 0, 1);
    beat(0, 0, 0, 1, 0);
    look("R4 rx idle ignored", 0, 0);

    // R3: valid without ready does not start the timer
    for (int i = 0; i < 5; i++) beat(1, 0, 0, 0, 0);
    look("R3 no ready no start", 0, 0);

    // vector table: R3 / R4 result equals rx distance
    for (int i = 0; i < 7; i++) begin
      run_vec(int'(VEC[i][23:16]), int'(VEC[i][15:8]), int'(VEC[i][7:0]));
      look($sformatf("R4 vec%0d", i), {24'd0, VEC[i][7:0]}, 1);
    end

    // R5: result frozen while done
    beat(1, 1, 1, 0, 0);
    repeat (3) beat(0, 0, 0, 0, 0);
    beat(0, 0, 0, 1, 0);
    look("R5 held", 3, 1);

    // R2: start during a running measurement
    beat(0, 0, 0, 0, 1);
    beat(1, 1, 1, 0, 0);
    repeat (3) beat(0, 0, 0, 0, 0);
    look("R3 running count", 3, 0);
    beat(0, 0, 0, 0, 1);
    look("R2 start clears", 0, 0);
    repeat (3) beat(0, 0, 0, 0, 0);
    beat(0, 0, 0, 1, 0);
    look("R2 halted", 0, 0);

    // R6: start mid-packet, timer waits for the next head
    beat(1, 1, 0, 0, 0);
    beat(1, 1, 0, 0, 0);
    beat(1, 1, 0, 0, 1);
    beat(1, 1, 0, 0, 0);
    beat(1, 1, 1, 0, 0);
    look("R6 tail not timed", 0, 0);
    beat(1, 1, 0, 0, 0);
    repeat (3) beat(0, 0, 0, 0, 0);
    beat(1, 1, 1, 0, 1);
    look("R6 start with beat", 0, 0);
    beat(1, 1, 1, 0, 0);
    repeat (3) beat(0, 0, 0, 0, 0);
    beat(0, 0, 0, 1, 0);
    look("R6 next head timed", 4, 1);

    // R7: narrow instance saturates
    beat(0, 0, 0, 0, 1);
    beat(1, 1, 1, 0, 0);
    repeat (70) beat(0, 0, 0, 0, 0);
    look("R3 long run", 70, 0);
    chk("R7 saturated", {26'd0, cyc_s}, 63);
    beat(0, 0, 0, 1, 0);
    look("R4 long result", 72, 1);
    chk("R7 held at max", {26'd0, cyc_s}, 63);
    chk("R7 done", {31'd0, done_s}, 1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule